// File: doc/BRIEF.md
# Secure Peripheral Access Guard

This block holds the access policy that separates secure and non-secure bus masters on a chip. It keeps a set of protection words with one bit for each protected on-chip peripheral. A bit at 1 opens that peripheral to non-secure masters. A bit at 0 keeps the peripheral secure-only. The block also holds a secure-size limit for an on-chip RAM. RAM below the limit is secure-only, and RAM at or above the limit is open to non-secure masters.

Software programs the block through a small memory-mapped register port, and every write carries a secure attribute. Each protection word has three addresses. One reads the word. One sets the bits written as 1. One clears the bits written as 1. A single bit can therefore change in one write, with no read-modify-write sequence. A separate check port takes one access per cycle: a secure flag, a target (a peripheral index or a RAM address), and a valid strobe. It answers with a registered deny flag one cycle later.

With default parameters the block has three protection words, which cover peripherals 0 to 95. The RAM is 64 KiB, split into sixteen 4 KiB granules.

Top module: `periph_guard`

## Requirements
- R1: After a synchronous reset, every protection bit is 0, the RAM secure limit equals the full granule count (16), read data is 0 and no check response is valid.
- R2: A secure write to a set address (0x804, 0x810, 0x81C for words 0, 1, 2) makes each bit written as 1 become 1 on the next clock edge, and leaves every other bit unchanged.
- R3: A secure write to a clear address (0x808, 0x814, 0x820 for words 0, 1, 2) makes each bit written as 1 become 0, and leaves every other bit unchanged.
- R4: A secure read of a status address (0x800, 0x80C, 0x818 for words 0, 1, 2) returns that protection word on reg_rdata in the cycle after the read strobe.
- R5: A secure write to offset 0x000 sets the RAM secure limit, in 4 KiB granules, to the written value. A value above 16 is stored as 16. A secure read of 0x000 returns the limit.
- R6: A write without the secure attribute changes no protection bit and does not change the RAM limit.
- R7: reg_rdata is 0 after a read that is non-secure, after a read of a set or clear address, and after a read of an unmapped or non-word-aligned address.
- R8: A check with chk_secure = 1 is always allowed. A non-secure peripheral check is denied when the peripheral's bit is 0 or the index is 96 or more; peripheral p maps to word p/32, bit p%32. chk_resp_valid and chk_deny appear one cycle after chk_valid.
- R9: A non-secure RAM check (chk_to_ram = 1) is denied exactly when the RAM address is below limit × 4096.
- R10: Bit 3 of word 0 guards the device reset/configuration peripheral (index 3). Setting it lets non-secure checks of index 3 pass, and clearing it denies them again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_secure | input | 1 | Secure attribute of the register access |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| prot_bits | output | 96 | All protection words, word 0 in the low bits |
| ram_sec_limit | output | 5 | RAM secure limit in granules |
| chk_valid | input | 1 | Access check strobe |
| chk_secure | input | 1 | Access is from a secure master |
| chk_to_ram | input | 1 | 1: RAM access, 0: peripheral access |
| chk_periph | input | 7 | Peripheral index |
| chk_ram_addr | input | 16 | RAM byte address |
| chk_resp_valid | output | 1 | Check response valid |
| chk_deny | output | 1 | Access denied |

## Verification
The hardest cases to reach are the edges of the policy. One is a RAM address exactly at the limit granule versus one byte below it. Others are a peripheral index past the last implemented word, and a non-secure write landing on a set or clear address whose bits would otherwise flip. Directed steps program the limit to chosen values, including 0, the maximum, and an over-range value that must be clamped. They then probe the addresses on both sides of each boundary. Seeded random traffic mixes secure and non-secure writes, reads and checks, so that ignored writes are followed by status reads and checks that would reveal any leak.

// File: rtl/pguard_pkg.sv
package pguard_pkg;

    localparam int unsigned REG_AW    = 12;
    localparam int unsigned REG_DW    = 32;
    localparam int unsigned MAX_WORDS = 16;
    localparam logic [REG_AW-1:0] LIMIT_OFS = 12'h000;
    localparam logic [REG_AW-1:0] PROT_OFS  = 12'h800;
    localparam int unsigned PROT_STRIDE = 12;

    typedef enum logic [1:0] {
        ACC_STAT = 2'd0,
        ACC_SET  = 2'd1,
        ACC_CLR  = 2'd2,
        ACC_NONE = 2'd3
    } prot_acc_e;

    typedef struct packed {
        logic      limit_hit;
        logic      prot_hit;
        logic [3:0] word_sel;
        prot_acc_e acc;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [REG_AW-1:0] a,
                                             input int unsigned nwords);
        reg_dec_t d;
        logic [REG_AW-1:0] o;
        d = '0;
        d.acc = ACC_NONE;
        if (a == LIMIT_OFS) d.limit_hit = 1'b1;
        for (int w = 0; w < MAX_WORDS; w++) begin
            for (int s = 0; s < 3; s++) begin
                o = PROT_OFS + REG_AW'(w * PROT_STRIDE + s * 4);
                if (w < int'(nwords) && a == o) begin
                    d.prot_hit = 1'b1;
                    d.word_sel = 4'(w);
                    d.acc      = prot_acc_e'(2'(s));
                end
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/pguard_regdec.sv
module pguard_regdec
    import pguard_pkg::*;
#(
    parameter int unsigned NWORDS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              secure,
    input  logic [REG_AW-1:0] addr,
    output reg_dec_t          dec,
    output logic [NWORDS-1:0] set_we,
    output logic [NWORDS-1:0] clr_we,
    output logic              limit_we
);

    logic wr_ok;

    assign dec      = decode_addr(addr, NWORDS);
    assign wr_ok    = wr_en && secure;
    assign limit_we = wr_ok && dec.limit_hit;

    for (genvar w = 0; w < NWORDS; w++) begin : g_strobe
        assign set_we[w] = wr_ok && dec.prot_hit && dec.word_sel == 4'(w) && dec.acc == ACC_SET;
        assign clr_we[w] = wr_ok && dec.prot_hit && dec.word_sel == 4'(w) && dec.acc == ACC_CLR;
    end

    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_we, clr_we, limit_we}));

    assert_ns_no_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        !secure |-> (set_we == '0 && clr_we == '0 && !limit_we));

endmodule

// File: rtl/pguard_protword.sv
module pguard_protword
    import pguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [REG_DW-1:0] wdata,
    output logic [REG_DW-1:0] word_q
);

    always_ff @(posedge clk) begin
        if (rst)         word_q <= '0;
        else if (clr_we) word_q <= word_q & ~wdata;
        else if (set_we) word_q <= word_q | wdata;
    end

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
        (set_we && !clr_we) |=> ((word_q & $past(wdata)) == $past(wdata)));

    assert_clear_bits_R3: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((word_q & $past(wdata)) == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(word_q));

endmodule

// File: rtl/pguard_ramsplit.sv
module pguard_ramsplit
    import pguard_pkg::*;
#(
    parameter int unsigned RAM_AW  = 16,
    parameter int unsigned GRAN_LG = 12,
    localparam int unsigned GIDX_W   = RAM_AW - GRAN_LG,
    localparam int unsigned LIM_W    = GIDX_W + 1,
    localparam int unsigned GRANULES = 1 << GIDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              limit_we,
    input  logic [REG_DW-1:0] wdata,
    input  logic [RAM_AW-1:0] ram_addr,
    output logic [LIM_W-1:0]  limit_q,
    output logic              in_secure
);

    always_ff @(posedge clk) begin
        if (rst)
            limit_q <= LIM_W'(GRANULES);
        else if (limit_we)
            limit_q <= (wdata > REG_DW'(GRANULES)) ? LIM_W'(GRANULES) : wdata[LIM_W-1:0];
    end

    assign in_secure = {1'b0, ram_addr} < {limit_q, {GRAN_LG{1'b0}}};

    assert_limit_bound_R5: assert property (@(posedge clk) disable iff (rst)
        limit_q <= LIM_W'(GRANULES));

    assert_limit_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !limit_we |=> $stable(limit_q));

endmodule

// File: rtl/periph_guard.sv
module periph_guard
    import pguard_pkg::*;
#(
    parameter int unsigned NWORDS  = 3,
    parameter int unsigned RAM_AW  = 16,
    parameter int unsigned GRAN_LG = 12,
    localparam int unsigned NPERIPH = NWORDS * REG_DW,
    localparam int unsigned PIDX_W  = $clog2(NPERIPH),
    localparam int unsigned LIM_W   = RAM_AW - GRAN_LG + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reg_wr_en,
    input  logic                      reg_rd_en,
    input  logic                      reg_secure,
    input  logic [REG_AW-1:0]         reg_addr,
    input  logic [REG_DW-1:0]         reg_wdata,
    output logic [REG_DW-1:0]         reg_rdata,
    output logic [NWORDS*REG_DW-1:0]  prot_bits,
    output logic [LIM_W-1:0]          ram_sec_limit,
    input  logic                      chk_valid,
    input  logic                      chk_secure,
    input  logic                      chk_to_ram,
    input  logic [PIDX_W-1:0]         chk_periph,
    input  logic [RAM_AW-1:0]         chk_ram_addr,
    output logic                      chk_resp_valid,
    output logic                      chk_deny
);

    reg_dec_t          dec;
    logic [NWORDS-1:0] set_we, clr_we;
    logic              limit_we;
    logic              ram_in_secure;
    logic              periph_open;
    logic              deny_d;
    logic [REG_DW-1:0] rd_val;

    pguard_regdec #(.NWORDS(NWORDS)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .secure   (reg_secure),
        .addr     (reg_addr),
        .dec      (dec),
        .set_we   (set_we),
        .clr_we   (clr_we),
        .limit_we (limit_we)
    );

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        pguard_protword u_word (
            .clk    (clk),
            .rst    (rst),
            .set_we (set_we[w]),
            .clr_we (clr_we[w]),
            .wdata  (reg_wdata),
            .word_q (prot_bits[w*REG_DW +: REG_DW])
        );
    end

    pguard_ramsplit #(.RAM_AW(RAM_AW), .GRAN_LG(GRAN_LG)) u_ram (
        .clk       (clk),
        .rst       (rst),
        .limit_we  (limit_we),
        .wdata     (reg_wdata),
        .ram_addr  (chk_ram_addr),
        .limit_q   (ram_sec_limit),
        .in_secure (ram_in_secure)
    );

    always_comb begin
        rd_val = '0;
        if (reg_secure) begin
            if (dec.limit_hit)
                rd_val = REG_DW'(ram_sec_limit);
            for (int w = 0; w < NWORDS; w++)
                if (dec.prot_hit && dec.acc == ACC_STAT && dec.word_sel == 4'(w))
                    rd_val = prot_bits[w*REG_DW +: REG_DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) reg_rdata <= '0;
        else     reg_rdata <= reg_rd_en ? rd_val : '0;
    end

    always_comb begin
        periph_open = 1'b0;
        for (int p = 0; p < NPERIPH; p++)
            if (int'(chk_periph) == p) periph_open = prot_bits[p];
    end

    assign deny_d = chk_valid && !chk_secure &&
                    (chk_to_ram ? ram_in_secure : !periph_open);

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_resp_valid <= 1'b0;
            chk_deny       <= 1'b0;
        end else begin
            chk_resp_valid <= chk_valid;
            chk_deny       <= deny_d;
        end
    end

    assert_secure_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_secure) |=> (chk_resp_valid && !chk_deny));

    assert_deny_valid_R8: assert property (@(posedge clk) disable iff (rst)
        chk_deny |-> chk_resp_valid);

    assert_ns_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && !reg_secure) |=> (reg_rdata == '0));

    assert_devcfg_closed_R10: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && !chk_secure && !chk_to_ram && chk_periph == PIDX_W'(3) && !prot_bits[3])
        |=> chk_deny);

endmodule

// File: tb/test_periph_guard.sv
module test_periph_guard;

    localparam int NW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 0, reg_rd_en = 0, reg_secure = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [95:0] prot_bits;
    logic [4:0]  ram_sec_limit;
    logic        chk_valid = 0, chk_secure = 0, chk_to_ram = 0;
    logic [6:0]  chk_periph = '0;
    logic [15:0] chk_ram_addr = '0;
    logic        chk_resp_valid, chk_deny;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] m_word [NW];
    int          m_lim;

    always #10 clk = ~clk;

    periph_guard i_periph_guard (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_secure(reg_secure), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .prot_bits(prot_bits), .ram_sec_limit(ram_sec_limit),
        .chk_valid(chk_valid), .chk_secure(chk_secure), .chk_to_ram(chk_to_ram),
        .chk_periph(chk_periph), .chk_ram_addr(chk_ram_addr),
        .chk_resp_valid(chk_resp_valid), .chk_deny(chk_deny)
    );

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [95:0] exp_bits();
        return {m_word[2], m_word[1], m_word[0]};
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a, input bit sec);
        if (!sec) return '0;
        if (a == 12'h000) return 32'(m_lim);
        for (int w = 0; w < NW; w++)
            if (a == 12'(12'h800 + w * 12)) return m_word[w];
        return '0;
    endfunction

    function automatic bit exp_deny(input bit sec, input bit ram, input int p, input int ra);
        if (sec) return 1'b0;
        if (ram) return ra < m_lim * 4096;
        if (p >= NW * 32) return 1'b1;
        return !m_word[p / 32][p % 32];
    endfunction

    task automatic check_state(input string req);
        check(prot_bits == exp_bits(), req, prot_bits, exp_bits());
        check(int'(ram_sec_limit) == m_lim, req, 96'(ram_sec_limit), 96'(m_lim));
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input bit sec, input string req);
        @(negedge clk);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d; reg_secure = sec;
        @(negedge clk);
        reg_wr_en = 0;
        if (sec) begin
            if (a == 12'h000) m_lim = (d > 16) ? 16 : int'(d);
            for (int w = 0; w < NW; w++) begin
                if (a == 12'(12'h804 + w * 12)) m_word[w] = m_word[w] | d;
                if (a == 12'(12'h808 + w * 12)) m_word[w] = m_word[w] & ~d;
            end
        end
        check_state(req);
    endtask

    task automatic do_read(input logic [11:0] a, input bit sec, input string req);
        logic [31:0] e;
        @(negedge clk);
        reg_rd_en = 1; reg_addr = a; reg_secure = sec;
        e = exp_read(a, sec);
        @(negedge clk);
        check(reg_rdata == e, req, 96'(reg_rdata), 96'(e));
        reg_rd_en = 0;
    endtask

    task automatic do_check(input bit sec, input bit ram, input int p, input int ra, input string req);
        bit e;
        @(negedge clk);
        chk_valid = 1; chk_secure = sec; chk_to_ram = ram;
        chk_periph = 7'(p); chk_ram_addr = 16'(ra);
        e = exp_deny(sec, ram, p, ra);
        @(negedge clk);
        check(chk_resp_valid && chk_deny == e, req, {chk_resp_valid, chk_deny}, {1'b1, e});
        chk_valid = 0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd5171);
        for (int w = 0; w < NW; w++) m_word[w] = '0;
        m_lim = 16;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1 reset state
        @(negedge clk);
        check_state("R1");
        check(reg_rdata == 0 && !chk_resp_valid, "R1", {reg_rdata, chk_resp_valid}, '0);

        // R10 device config peripheral closed, then opened, then closed
        do_check(0, 0, 3, 0, "R10 closed");
        do_write(12'h804, 32'h0000_0008, 1, "R2 R10 set");
        do_check(0, 0, 3, 0, "R10 open");
        do_check(0, 0, 2, 0, "R8 neighbour");
        // R2 set ORs into other bits
        do_write(12'h810, 32'hA5A5_0000, 1, "R2 word1");
        do_write(12'h810, 32'h0000_00F0, 1, "R2 word1 or");
        do_write(12'h81C, 32'h8000_0001, 1, "R2 word2");
        // R4 status reads
        do_read(12'h800, 1, "R4 w0");
        do_read(12'h80C, 1, "R4 w1");
        do_read(12'h818, 1, "R4 w2");
        // R3 clear
        do_write(12'h814, 32'hA000_00F0, 1, "R3 word1");
        do_write(12'h808, 32'h0000_0008, 1, "R3 R10 clear");
        do_check(0, 0, 3, 0, "R10 reclosed");
        // R6 non-secure writes ignored
        do_write(12'h804, 32'hFFFF_FFFF, 0, "R6 set");
        do_write(12'h820, 32'hFFFF_FFFF, 0, "R6 clr");
        do_write(12'h000, 32'd2, 0, "R6 limit");
        do_read(12'h818, 1, "R6 readback");
        // R7 zero reads
        do_read(12'h80C, 0, "R7 ns status");
        do_read(12'h81C, 1, "R7 set addr");
        do_read(12'h808, 1, "R7 clr addr");
        do_read(12'h824, 1, "R7 unmapped");
        do_read(12'h801, 1, "R7 misaligned");
        // R8 out of range and secure
        do_check(0, 0, 100, 0, "R8 out of range");
        do_check(1, 0, 100, 0, "R8 secure");
        do_check(0, 0, 95, 0, "R8 last");
        // R5 / R9 limit
        do_read(12'h000, 1, "R5 reset limit");
        do_check(0, 1, 0, 16'hFFFF, "R9 all secure");
        do_write(12'h000, 32'd5, 1, "R5 limit 5");
        do_check(0, 1, 0, 16'h4FFF, "R9 below");
        do_check(0, 1, 0, 16'h5000, "R9 at limit");
        do_check(1, 1, 0, 16'h0000, "R9 secure");
        do_write(12'h000, 32'd100, 1, "R5 clamp");
        do_read(12'h000, 1, "R5 readback");
        do_write(12'h000, 32'd0, 1, "R5 zero");
        do_check(0, 1, 0, 16'h0000, "R9 none secure");

        // seeded random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned k = $urandom % 6;
            int unsigned w = $urandom % NW;
            bit sec = ($urandom % 4) != 0;
            case (k)
                0: do_write(12'(12'h804 + w * 12), $urandom & $urandom, sec, "R2 rand");
                1: do_write(12'(12'h808 + w * 12), $urandom & $urandom, sec, "R3 rand");
                2: do_write(12'h000, 32'($urandom % 24), sec, "R5 rand");
                3: do_read(12'(12'h800 + ($urandom % 12) * 4), sec, "R4 R7 rand");
                4: do_check(sec, 0, int'($urandom % 128), 0, "R8 rand");
                default: do_check(sec, 1, 0, int'($urandom % 65536), "R9 rand");
            endcase
        end

        finish_up();
    end

endmodule